// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of five clock sources feeds the system clock. Software asks for a source by writing a 3-bit code into a select field. Hardware can overwrite that field. On a wake event from a low-power mode it puts the field back to the internal high-speed default. It does the same when the external high-speed oscillator fails while that oscillator is the one selected. A hardware override always beats a software write made in the same cycle.

A separate 3-bit status field shows the source that is actually driving the clock. It follows the select field only after the target source reports ready, so the status can trail the request by any number of cycles. The block also drives a one-hot enable vector for a downstream glitch-free clock mux. That vector is decoded from the status field one cycle after the status changes, so exactly one mux leg is enabled at any time. The block contains no clock mux cells and no oscillators.

Source codes: 000 internal high-speed (default), 001 external high-speed, 010 PLL R output, 011 internal low-speed, 100 external low-speed. Codes 101 to 111 are reserved. Bit i of the ready input and of the enable output belongs to the source whose code is i.

Top module: `sysclk_src_ctrl`

## Requirements
- R1: After reset, the select field and the status field are both 000, and the mux enable is 00001 (bit 0 set).
- R2: A write of a code from 000 to 100 replaces the select field on the next clock edge, unless a hardware override is active in the same cycle.
- R3: A write of a reserved code (101, 110, 111) is ignored, and the select field keeps its previous value.
- R4: If the status differs from the select field and the ready bit of the selected source is 0, the status holds. If that ready bit is 1, the status takes the select field's value on the next edge.
- R5: A wake event forces the select field to 000 on the next edge, even when a software write happens in the same cycle.
- R6: An external oscillator failure while the select field holds 001 forces the select field to 000 on the next edge, even when a software write happens in the same cycle.
- R7: An external oscillator failure while the select field holds any code other than 001 has no effect on the select field.
- R8: The mux enable always has exactly one bit set. It equals the one-hot decode of the status field as it stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr_en | input | 1 | Software write strobe for the select field |
| sel_wr_code | input | 3 | Code being written to the select field |
| src_ready | input | 5 | Ready flag of each source, bit i for code i |
| ext_hs_fail | input | 1 | Failure flag of the external high-speed oscillator |
| wake_evt | input | 1 | Wake from a low-power mode |
| sel_o | output | 3 | Current select field |
| stat_o | output | 3 | Source actually in use |
| mux_en_o | output | 5 | One-hot enables for the glitch-free clock mux |

## Verification
A corrupted select register shows on `sel_o` at the very next edge. A stuck or wrong override shows there too, as a missing or spurious return to 000. Faults in the status tracking appear on `stat_o`: it either moves while the target is not ready or fails to move one edge after ready rises. A wrong decoder shows on `mux_en_o` one cycle after the status changes, as a wrong bit or as a count of set bits other than one. The bench compares all three outputs every cycle against a model built from the requirements.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
   localparam int unsigned SRC_CODE_W = 3;
   localparam int unsigned SRC_COUNT  = 5;

   typedef enum logic [SRC_CODE_W-1:0] {
      SRC_INT_HS = 3'd0,
      SRC_EXT_HS = 3'd1,
      SRC_PLL_R  = 3'd2,
      SRC_INT_LS = 3'd3,
      SRC_EXT_LS = 3'd4
   } src_code_e;
endpackage

// File: rtl/src_sel_reg.sv
// Select field: software writes, hardware overrides with priority.
module src_sel_reg #(
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned NUM_SRC     = 5,
   parameter int unsigned DFLT_CODE   = 0,
   parameter int unsigned EXT_HS_CODE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_code,
   input  logic             hs_fail,
   input  logic             wake,
   output logic [SEL_W-1:0] sel_q
);
   localparam logic [SEL_W-1:0] DFLT = SEL_W'(DFLT_CODE);
   localparam logic [SEL_W-1:0] EXTH = SEL_W'(EXT_HS_CODE);

   logic code_ok;
   logic hw_force;
   logic [SEL_W-1:0] sel_d;

   assign code_ok  = (int'(wr_code) < int'(NUM_SRC));
   assign hw_force = wake | (hs_fail & (sel_q == EXTH));

   always_comb begin
      sel_d = sel_q;
      if (hw_force)
         sel_d = DFLT;
      else if (wr_en && code_ok)
         sel_d = wr_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= DFLT;
      else        sel_q <= sel_d;
   end
endmodule

// File: rtl/src_switch_track.sv
// Status field: follows the select field once the target source is ready.
module src_switch_track #(
   parameter int unsigned SEL_W     = 3,
   parameter int unsigned NUM_SRC   = 5,
   parameter int unsigned DFLT_CODE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [NUM_SRC-1:0] ready_i,
   output logic [SEL_W-1:0]   stat_q
);
   logic tgt_rdy;

   always_comb begin
      tgt_rdy = 1'b0;
      for (int i = 0; i < int'(NUM_SRC); i++)
         if (sel_i == SEL_W'(i)) tgt_rdy = ready_i[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_q <= SEL_W'(DFLT_CODE);
      else if ((stat_q != sel_i) && tgt_rdy)
         stat_q <= sel_i;
   end
endmodule

// File: rtl/src_onehot_drv.sv
// One-hot mux enables decoded from the status field.
module src_onehot_drv #(
   parameter int unsigned SEL_W     = 3,
   parameter int unsigned NUM_SRC   = 5,
   parameter int unsigned DFLT_CODE = 0,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEL_W-1:0]   stat_i,
   output logic [NUM_SRC-1:0] en_o
);
   logic [NUM_SRC-1:0] en_d;

   for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_dec
      assign en_d[i] = (stat_i == SEL_W'(i));
   end

   if (REG_OUT) begin : g_reg
      logic [NUM_SRC-1:0] en_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_q <= NUM_SRC'(1) << DFLT_CODE;
         else        en_q <= en_d;
      end
      assign en_o = en_q;
   end else begin : g_comb
      assign en_o = en_d;
   end
endmodule

// File: rtl/sysclk_src_ctrl.sv
module sysclk_src_ctrl #(
   parameter int unsigned SEL_W       = sysclk_pkg::SRC_CODE_W,
   parameter int unsigned NUM_SRC     = sysclk_pkg::SRC_COUNT,
   parameter int unsigned DFLT_CODE   = int'(sysclk_pkg::SRC_INT_HS),
   parameter int unsigned EXT_HS_CODE = int'(sysclk_pkg::SRC_EXT_HS),
   parameter bit          MUX_REG     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_wr_en,
   input  logic [SEL_W-1:0]   sel_wr_code,
   input  logic [NUM_SRC-1:0] src_ready,
   input  logic               ext_hs_fail,
   input  logic               wake_evt,
   output logic [SEL_W-1:0]   sel_o,
   output logic [SEL_W-1:0]   stat_o,
   output logic [NUM_SRC-1:0] mux_en_o
);
   if (NUM_SRC > (1 << SEL_W)) begin : g_bad_width
      $error("sysclk_src_ctrl: NUM_SRC does not fit in SEL_W bits");
   end
   if (DFLT_CODE >= NUM_SRC) begin : g_bad_dflt
      $error("sysclk_src_ctrl: DFLT_CODE out of range");
   end
   if (EXT_HS_CODE >= NUM_SRC) begin : g_bad_ext
      $error("sysclk_src_ctrl: EXT_HS_CODE out of range");
   end

   logic [SEL_W-1:0] sel_w;
   logic [SEL_W-1:0] stat_w;

   src_sel_reg #(
      .SEL_W(SEL_W), .NUM_SRC(NUM_SRC),
      .DFLT_CODE(DFLT_CODE), .EXT_HS_CODE(EXT_HS_CODE)
   ) u_sel (
      .clk(clk), .rst_n(rst_n), .wr_en(sel_wr_en), .wr_code(sel_wr_code),
      .hs_fail(ext_hs_fail), .wake(wake_evt), .sel_q(sel_w)
   );

   src_switch_track #(
      .SEL_W(SEL_W), .NUM_SRC(NUM_SRC), .DFLT_CODE(DFLT_CODE)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_w), .ready_i(src_ready),
      .stat_q(stat_w)
   );

   src_onehot_drv #(
      .SEL_W(SEL_W), .NUM_SRC(NUM_SRC), .DFLT_CODE(DFLT_CODE), .REG_OUT(MUX_REG)
   ) u_drv (
      .clk(clk), .rst_n(rst_n), .stat_i(stat_w), .en_o(mux_en_o)
   );

   assign sel_o  = sel_w;
   assign stat_o = stat_w;
endmodule

// File: rtl/sysclk_src_ctrl_chk.sv
module sysclk_src_ctrl_chk #(
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned NUM_SRC     = 5,
   parameter int unsigned EXT_HS_CODE = 1,
   parameter bit          MUX_REG     = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sel_wr_en,
   input logic [SEL_W-1:0]   sel_wr_code,
   input logic [NUM_SRC-1:0] src_ready,
   input logic               ext_hs_fail,
   input logic               wake_evt,
   input logic [SEL_W-1:0]   sel_o,
   input logic [SEL_W-1:0]   stat_o,
   input logic [NUM_SRC-1:0] mux_en_o
);
   logic ovr;
   assign ovr = wake_evt | (ext_hs_fail & (sel_o == SEL_W'(EXT_HS_CODE)));

   p_write_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr_en && !ovr && (int'(sel_wr_code) < int'(NUM_SRC)))
      |=> (sel_o == $past(sel_wr_code)));

   p_reserved_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr_en && !ovr && (int'(sel_wr_code) >= int'(NUM_SRC))) |=> $stable(sel_o));

   p_hold_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_o != sel_o) && !src_ready[sel_o]) |=> $stable(stat_o));

   p_switch_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_o != sel_o) && src_ready[sel_o]) |=> (stat_o == $past(sel_o)));

   p_wake_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> (sel_o == '0));

   p_fail_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_hs_fail && (sel_o == SEL_W'(EXT_HS_CODE))) |=> (sel_o == '0));

   p_fail_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_hs_fail && !wake_evt && !sel_wr_en && (sel_o != SEL_W'(EXT_HS_CODE)))
      |=> $stable(sel_o));

   p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mux_en_o) == 1);

   if (MUX_REG) begin : g_lag
      p_mux_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> mux_en_o[$past(stat_o)]);
   end
endmodule

bind sysclk_src_ctrl sysclk_src_ctrl_chk #(
   .SEL_W(SEL_W), .NUM_SRC(NUM_SRC), .EXT_HS_CODE(EXT_HS_CODE), .MUX_REG(MUX_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_wr_en(sel_wr_en), .sel_wr_code(sel_wr_code),
   .src_ready(src_ready), .ext_hs_fail(ext_hs_fail), .wake_evt(wake_evt),
   .sel_o(sel_o), .stat_o(stat_o), .mux_en_o(mux_en_o)
);

// File: tb/sysclk_src_ctrl_tb_top.sv
module sysclk_src_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_wr_en = 1'b0;
   logic [2:0] sel_wr_code = '0;
   logic [4:0] src_ready = 5'b11111;
   logic       ext_hs_fail = 1'b0;
   logic       wake_evt = 1'b0;
   logic [2:0] sel_o;
   logic [2:0] stat_o;
   logic [4:0] mux_en_o;

   always #10 clk = ~clk;

   sysclk_src_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .sel_wr_en(sel_wr_en), .sel_wr_code(sel_wr_code),
      .src_ready(src_ready), .ext_hs_fail(ext_hs_fail), .wake_evt(wake_evt),
      .sel_o(sel_o), .stat_o(stat_o), .mux_en_o(mux_en_o)
   );

   typedef struct {
      logic [2:0] sel;
      logic [2:0] stat;
      logic [4:0] mux;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   logic [2:0] m_sel = '0;
   logic [2:0] m_stat = '0;
   logic [4:0] m_mux = 5'b00001;

   // Driver: apply one cycle of stimulus, work out the expected state after the edge.
   task automatic step(input bit wr, input logic [2:0] code, input logic [4:0] rdy,
                       input bit fail, input bit wake, input string tag);
      logic [2:0] n_sel, n_stat;
      logic [4:0] n_mux;
      exp_t e;
      @(negedge clk);
      sel_wr_en = wr; sel_wr_code = code; src_ready = rdy;
      ext_hs_fail = fail; wake_evt = wake;
      if (wake || (fail && m_sel == 3'd1)) n_sel = 3'd0;
      else if (wr && code < 3'd5)           n_sel = code;
      else                                  n_sel = m_sel;
      n_stat = (m_stat != m_sel && rdy[m_sel]) ? m_sel : m_stat;
      n_mux  = 5'b00001 << m_stat;
      m_sel = n_sel; m_stat = n_stat; m_mux = n_mux;
      e.sel = n_sel; e.stat = n_stat; e.mux = n_mux; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: compare just after each edge.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_run++;
            if (sel_o !== e.sel || stat_o !== e.stat || mux_en_o !== e.mux) begin
               n_fail++;
               $display("FAIL %s: sel/stat/mux got %0d/%0d/%b expected %0d/%0d/%b",
                        e.tag, sel_o, stat_o, mux_en_o, e.sel, e.stat, e.mux);
            end
         end
      end
   end

   initial begin
      #100000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: run hung, got no end expected end");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #3;
      n_run++;
      if (sel_o !== 3'd0 || stat_o !== 3'd0 || mux_en_o !== 5'b00001) begin
         n_fail++;
         $display("FAIL R1: reset got %0d/%0d/%b expected 0/0/00001", sel_o, stat_o, mux_en_o);
      end
      @(negedge clk); rst_n = 1'b1;
      step(0, 3'd0, 5'b11111, 0, 0, "R1 idle");
      // R2 write PLL while not ready, R4 hold
      step(1, 3'd2, 5'b11011, 0, 0, "R2 write 010");
      step(0, 3'd0, 5'b11011, 0, 0, "R4 hold not ready");
      step(0, 3'd0, 5'b11011, 0, 0, "R4 hold not ready");
      step(0, 3'd0, 5'b11111, 0, 0, "R4 switch on ready");
      step(0, 3'd0, 5'b11111, 0, 0, "R8 mux follows status");
      // R3 reserved codes
      step(1, 3'd5, 5'b11111, 0, 0, "R3 write 101");
      step(1, 3'd7, 5'b11111, 0, 0, "R3 write 111");
      step(1, 3'd6, 5'b11111, 0, 0, "R3 write 110");
      // R7 fail on other source, then R2 to ext HS
      step(0, 3'd0, 5'b11111, 1, 0, "R7 fail while 010");
      step(1, 3'd1, 5'b11111, 0, 0, "R2 write 001");
      step(0, 3'd0, 5'b11111, 0, 0, "R4 status to 001");
      step(0, 3'd0, 5'b11111, 0, 0, "R8 mux 00010");
      step(0, 3'd0, 5'b11101, 1, 0, "R6 fail while 001");
      step(0, 3'd0, 5'b11101, 0, 0, "R4 back to 000");
      step(0, 3'd0, 5'b11101, 0, 0, "R8 mux 00001");
      // fail with write of 001 while 000 selected: write wins (R7)
      step(1, 3'd1, 5'b11111, 1, 0, "R7 fail while 000 with write");
      step(1, 3'd3, 5'b11111, 1, 0, "R6 fail beats write");
      step(1, 3'd3, 5'b11111, 0, 0, "R2 write 011");
      step(0, 3'd0, 5'b11111, 1, 0, "R7 fail while 011");
      step(1, 3'd4, 5'b11111, 0, 1, "R5 wake beats write");
      step(1, 3'd4, 5'b01111, 0, 0, "R2 write 100");
      step(0, 3'd0, 5'b01111, 0, 0, "R4 ext LS not ready");
      step(0, 3'd0, 5'b10000, 0, 0, "R4 ext LS ready");
      step(0, 3'd0, 5'b10000, 0, 1, "R5 wake from 100");
      step(0, 3'd0, 5'b00000, 0, 0, "R4 default not ready");
      step(0, 3'd0, 5'b00001, 0, 0, "R4 default ready");
      step(0, 3'd0, 5'b00001, 0, 0, "R8 mux back to 00001");
      step(0, 3'd0, 5'b11111, 0, 0, "R1 quiet");
      repeat (3) @(posedge clk);
      #5;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule